// File: doc/BRIEF.md
# Start-Up Reference Ramp Sequencer

This block generates the reference code that a multiphase buck regulator's DAC follows while the output comes up. After enable it waits a fixed time, then raises the reference one code unit (6.25 mV) at a time at a programmable step rate. It also decides when the power stage's drivers may switch and when power-good may be reported. The delays and the default step period are counted in clock cycles and set by parameters. The step period can be changed at run time through `step_div`, and a value of zero selects the default period.

Two start-up profiles are offered. The staged profile ramps to a fixed 1.1 V plateau (code 176) and holds there for a set time. It then waits for a settled VID target before it ramps up or down to that target. The direct profile captures the target at enable and ramps straight to it. In both profiles the drivers stay off while the regulated output sits above the rising reference, as happens with a pre-charged output. They turn on as soon as the reference catches up, or at the end of the final ramp if it never does.

Top module: `softstart_seq`

## Requirements
- R1: While `en` is low, `dac_code`, `drv_en` and `pwr_good` are all zero. When `en` is sampled low at a clock edge, all three are zero after that edge, from any state.
- R2: The code only ever moves by exactly one unit per step. The step period P equals `step_div` when that input is nonzero, and `DEF_STEP` (4) when it is zero. The j-th step of a ramp appears j·P edges after the edge that starts the ramp.
- R3: In staged mode (`mode_single`=0), the code stays 0 for `TD1_T` (20) edges after the enable edge. It then rises to 176 and reaches that value 20+176·P edges after enable.
- R4: In staged mode the code stays at 176 for at least `HOLD_T` (6) cycles. It then waits until `vid_ok` has been high with `vid_code` unchanged for `VQ_T` (3) consecutive edges. The second ramp starts on the next edge.
- R5: The second ramp moves up or down toward the target and never goes past it. The code never exceeds the larger of 176 and the target in staged mode, or the target in direct mode.
- R6: In staged mode `pwr_good` rises `TD5_T` (10) edges after the ramp's final-code cycle. With VID already settled, this is 20+176·P+1+6+1+|N−176|·P+1+10 edges after enable, for a target N.
- R7: In direct mode (`mode_single`=1) the target is captured at the enable edge, and later `vid_code` changes have no effect. The code stays 0 for `TDA_T` (12) edges, then ramps from 0 to the captured target.
- R8: In direct mode `pwr_good` rises 12+N·P+1+15 edges after enable (`TDC_T`=15).
- R9: During a ramp, `drv_en` stays low while `fb_above` is high. On the first ramp edge that sees `fb_above` low, it goes high and stays high until `en` falls.
- R10: If `fb_above` stays high through every ramp, `drv_en` rises on the edge that ends the final ramp.
- R11: `pwr_good` is high only while `dac_code` equals the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Start-up enable; low returns to idle |
| mode_single | input | 1 | 1 selects the direct single-ramp profile, 0 the staged profile |
| vid_code | input | CW | Target code in 6.25 mV units |
| vid_ok | input | 1 | Target code valid flag |
| fb_above | input | 1 | Feedback is above the present reference |
| step_div | input | DW | Step period in clocks; 0 selects DEF_STEP |
| dac_code | output | CW | Reference code in 6.25 mV units |
| drv_en | output | 1 | Power-stage driver enable |
| pwr_good | output | 1 | Power-good flag |

## Verification
Every result is registered once, so the bench counts edges from the edge that samples `en` high. It samples at the following falling edge and compares against arrival times that it computes from the delays, the step period, the target and a modelled feedback level. Power-good and driver-enable rise times are checked to the exact edge. The plateau value and the third step of the first ramp are checked at their predicted edges. The late-VID case checks the last plateau cycle and the first step cycle around VQ_T+P edges after `vid_ok` rises. A disable takes effect one edge later and is checked at the next sample. Between those points, every sample is screened for multi-unit jumps and for overshoot.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DLY, S_RAMP1, S_HOLD, S_WAITV, S_RAMP2, S_PGDLY, S_DONE
  } ss_state_e;
endpackage

// File: rtl/ss_timer.sv
module ss_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] len,
  output logic          done
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart)            cnt_d = '0;
    else if (cnt_q != '1)   cnt_d = cnt_q + 1'b1;
    else                    cnt_d = cnt_q;
    done = (cnt_q == len - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ss_vid_qual.sv
module ss_vid_qual #(
  parameter int CW   = 8,
  parameter int VQ_T = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] vid_code,
  input  logic          vid_ok,
  output logic          vid_good
);
  localparam int QW = $clog2(VQ_T + 1);
  localparam logic [QW-1:0] QMAX = QW'(VQ_T);

  logic [CW-1:0] prev_q;
  logic [QW-1:0] cnt_q, cnt_d;
  logic          steady;

  always_comb begin
    steady = vid_ok && (vid_code == prev_q);
    if (!steady)            cnt_d = '0;
    else if (cnt_q == QMAX) cnt_d = cnt_q;
    else                    cnt_d = cnt_q + 1'b1;
    vid_good = (cnt_q == QMAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= vid_code;
      cnt_q  <= cnt_d;
    end
  end

  assert_qual_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_good && !vid_ok) |=> !vid_good);
endmodule

// File: rtl/ss_stepper.sv
module ss_stepper #(
  parameter int CW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [DW-1:0] period,
  input  logic [CW-1:0] tgt,
  output logic [CW-1:0] code,
  output logic          at_tgt
);
  logic [CW-1:0] code_q, code_d;
  logic [DW-1:0] scnt_q, scnt_d;
  logic          up, tick;

  always_comb begin
    at_tgt = (code_q == tgt);
    up     = (code_q < tgt);
    tick   = run && !at_tgt && (scnt_q == period - 1'b1);
    scnt_d = (!run || tick) ? '0 : scnt_q + 1'b1;
    code_d = code_q;
    if (clr)       code_d = '0;
    else if (tick) code_d = up ? code_q + 1'b1 : code_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      scnt_q <= '0;
    end else begin
      code_q <= code_d;
      scnt_q <= scnt_d;
    end
  end

  assign code = code_q;

  assert_no_overshoot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && code_q < tgt) |=> (code_q >= $past(code_q) && code_q <= $past(tgt)));
  assert_no_undershoot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && code_q > tgt) |=> (code_q <= $past(code_q) && code_q >= $past(tgt)));
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ss_pkg::*;
#(
  parameter int CW       = 8,
  parameter int DW       = 4,
  parameter int TW       = 16,
  parameter int DEF_STEP = 4,
  parameter int PLATEAU  = 176,
  parameter int TD1_T    = 20,
  parameter int HOLD_T   = 6,
  parameter int VQ_T     = 3,
  parameter int TD5_T    = 10,
  parameter int TDA_T    = 12,
  parameter int TDC_T    = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          mode_single,
  input  logic [CW-1:0] vid_code,
  input  logic          vid_ok,
  input  logic          fb_above,
  input  logic [DW-1:0] step_div,
  output logic [CW-1:0] dac_code,
  output logic          drv_en,
  output logic          pwr_good
);
  localparam logic [CW-1:0] PLAT_C = CW'(PLATEAU);
  localparam logic [DW-1:0] DEF_C  = DW'(DEF_STEP);
  localparam logic [TW-1:0] TD1_L  = TW'(TD1_T);
  localparam logic [TW-1:0] HOLD_L = TW'(HOLD_T);
  localparam logic [TW-1:0] TD5_L  = TW'(TD5_T);
  localparam logic [TW-1:0] TDA_L  = TW'(TDA_T);
  localparam logic [TW-1:0] TDC_L  = TW'(TDC_T);

  ss_state_e     st_q, st_d;
  logic [CW-1:0] tgt_q, tgt_d, ramp_tgt;
  logic          mode_q, mode_d;
  logic          drv_q, drv_d, pg_q, pg_d;
  logic [TW-1:0] tlen;
  logic [DW-1:0] period;
  logic          tdone, vid_good, at_tgt, in_ramp, clr, final_exit;
  logic [CW-1:0] code;

  ss_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(st_d != st_q), .len(tlen), .done(tdone)
  );

  ss_vid_qual #(.CW(CW), .VQ_T(VQ_T)) u_qual (
    .clk(clk), .rst_n(rst_n), .vid_code(vid_code), .vid_ok(vid_ok), .vid_good(vid_good)
  );

  ss_stepper #(.CW(CW), .DW(DW)) u_step (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(in_ramp), .period(period),
    .tgt(ramp_tgt), .code(code), .at_tgt(at_tgt)
  );

  always_comb begin
    period     = (step_div == '0) ? DEF_C : step_div;
    in_ramp    = (st_q == S_RAMP1) || (st_q == S_RAMP2);
    ramp_tgt   = (st_q == S_RAMP1) ? PLAT_C : tgt_q;
    clr        = !en || (st_q == S_IDLE);
    final_exit = (st_q == S_RAMP2) && at_tgt;
    case (st_q)
      S_DLY:   tlen = mode_q ? TDA_L : TD1_L;
      S_HOLD:  tlen = HOLD_L;
      S_PGDLY: tlen = mode_q ? TDC_L : TD5_L;
      default: tlen = TW'(1);
    endcase
  end

  always_comb begin
    st_d   = st_q;
    tgt_d  = tgt_q;
    mode_d = mode_q;
    case (st_q)
      S_IDLE: if (en) begin
        st_d   = S_DLY;
        mode_d = mode_single;
        tgt_d  = mode_single ? vid_code : '0;
      end
      S_DLY:   if (tdone) st_d = mode_q ? S_RAMP2 : S_RAMP1;
      S_RAMP1: if (at_tgt) st_d = S_HOLD;
      S_HOLD:  if (tdone) st_d = S_WAITV;
      S_WAITV: if (vid_good) begin
        st_d  = S_RAMP2;
        tgt_d = vid_code;
      end
      S_RAMP2: if (at_tgt) st_d = S_PGDLY;
      S_PGDLY: if (tdone) st_d = S_DONE;
      default: st_d = S_DONE;
    endcase
    if (!en) st_d = S_IDLE;
    drv_d = en && (drv_q || (in_ramp && !fb_above) || final_exit);
    pg_d  = en && (st_d == S_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      tgt_q  <= '0;
      mode_q <= 1'b0;
      drv_q  <= 1'b0;
      pg_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      tgt_q  <= tgt_d;
      mode_q <= mode_d;
      drv_q  <= drv_d;
      pg_q   <= pg_d;
    end
  end

  assign dac_code = code;
  assign drv_en   = drv_q;
  assign pwr_good = pg_q;

  assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (dac_code == '0 && !drv_en && !pwr_good));
  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> (dac_code == $past(dac_code) || dac_code == $past(dac_code) + 1'b1
                           || dac_code + 1'b1 == $past(dac_code)));
  assert_pg_after_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> $past(st_q) == S_PGDLY);
  assert_drv_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_ramp && fb_above && !drv_en && !final_exit) |=> !drv_en);
  assert_drv_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && drv_en) |=> drv_en);
  assert_pg_on_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> dac_code == tgt_q);
endmodule

// File: tb/sim_softstart_seq.sv
module sim_softstart_seq;
  logic       clk, rst_n, en, mode_single, vid_ok, fb_above;
  logic [7:0] vid_code, dac_code;
  logic [3:0] step_div;
  logic       drv_en, pwr_good;
  int tot, bad, cyc, fb_level;

  softstart_seq u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_single(mode_single), .vid_code(vid_code),
    .vid_ok(vid_ok), .fb_above(fb_above), .step_div(step_div), .dac_code(dac_code),
    .drv_en(drv_en), .pwr_good(pwr_good)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tot++; bad++;
      $display("FAIL watchdog: act=%0d exp<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", tot, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int per(input int sd);
    return (sd == 0) ? 4 : sd;
  endfunction
  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction
  function automatic int ramp2_start(input int p);
    return 20 + 176 * p + 1 + 6 + 1;
  endfunction
  function automatic int exp_pg(input bit m, input int n, input int p);
    if (m) return 12 + n * p + 1 + 15;
    return ramp2_start(p) + absd(n, 176) * p + 1 + 10;
  endfunction
  function automatic int exp_drv(input bit m, input int n, input int p, input int l);
    if (m) return (l <= n) ? 12 + l * p + 1 : 12 + n * p + 1;
    if (l <= 176) return 20 + l * p + 1;
    if (n > 176 && l <= n) return ramp2_start(p) + (l - 176) * p + 1;
    return ramp2_start(p) + absd(n, 176) * p + 1;
  endfunction

  task automatic run_case(input bit m, input int n, input int sd, input int l);
    int p, epg, edrv, gpg, gdrv, viol, over, zerr, hi, d, prev, c;
    p = per(sd); epg = exp_pg(m, n, p); edrv = exp_drv(m, n, p, l);
    d = m ? 12 : 20; hi = m ? n : ((n > 176) ? n : 176);
    gpg = -1; gdrv = -1; viol = 0; over = 0; zerr = 0; prev = 0;
    @(negedge clk);
    mode_single = m; vid_code = 8'(n); step_div = 4'(sd); vid_ok = 1'b1;
    fb_level = l; fb_above = (l > 0); en = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= epg + 2; k++) begin
      @(negedge clk);
      c = int'(dac_code);
      if (k > 0 && absd(c, prev) > 1) viol++;
      if (c > hi) over++;
      if (k < d && c != 0) zerr++;
      if (k == d + 3 * p - 1 && (!m || n >= 3)) chk(c == 2, "R2 step timing", c, 2);
      if (k == d + 3 * p && (!m || n >= 3)) chk(c == 3, "R2 step timing", c, 3);
      if (!m && k == 20 + 176 * p) chk(c == 176, "R3 plateau", c, 176);
      if (pwr_good && gpg < 0) begin
        gpg = k;
        chk(c == n, "R11 code at power-good", c, n);
      end
      if (drv_en && gdrv < 0) gdrv = k;
      if (m && k == 2) vid_code = 8'(n ^ 8'h5A);
      fb_above = (fb_level > c);
      prev = c;
    end
    chk(gpg == epg, m ? "R8 pg time" : "R6 pg time", gpg, epg);
    chk(gdrv == edrv, (l > hi) ? "R10 drv at end" : "R9 drv rise", gdrv, edrv);
    chk(viol == 0, "R2 unit steps", viol, 0);
    chk(over == 0, "R5 no overshoot", over, 0);
    chk(zerr == 0, m ? "R7 delay zero" : "R3 delay zero", zerr, 0);
    if (m) chk(int'(dac_code) == n, "R7 captured target", int'(dac_code), n);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk(dac_code == 0 && !drv_en && !pwr_good, "R1 disable",
        int'(dac_code) + int'(drv_en) + int'(pwr_good), 0);
  endtask

  task automatic late_vid();
    int guard;
    @(negedge clk);
    mode_single = 1'b0; vid_code = 8'd200; vid_ok = 1'b0; step_div = 4'd0;
    fb_level = 0; fb_above = 1'b0; en = 1'b1;
    guard = 0;
    while (dac_code != 8'd176 && guard < 2000) begin
      @(negedge clk); guard++;
    end
    repeat (10) @(negedge clk);
    chk(dac_code == 8'd176 && !pwr_good, "R4 waits for vid", int'(dac_code), 176);
    vid_ok = 1'b1;
    for (int j = 0; j <= 9; j++) begin
      @(negedge clk);
      if (j == 6) chk(dac_code == 8'd176, "R4 last plateau cycle", int'(dac_code), 176);
      if (j == 7) chk(dac_code == 8'd177, "R4 first step after vid", int'(dac_code), 177);
    end
    en = 1'b0;
    @(negedge clk);
    chk(dac_code == 0 && !drv_en && !pwr_good, "R1 disable mid-ramp",
        int'(dac_code) + int'(drv_en) + int'(pwr_good), 0);
  endtask

  initial begin
    int seed;
    tot = 0; bad = 0;
    seed = $urandom(32'd2718);
    rst_n = 1'b0; en = 1'b0; mode_single = 1'b0; vid_ok = 1'b0; fb_above = 1'b0;
    vid_code = 8'd0; step_div = 4'd0; fb_level = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(dac_code == 0 && !drv_en && !pwr_good, "R1 reset state",
        int'(dac_code) + int'(drv_en) + int'(pwr_good), 0);
    run_case(1'b0, 176, 0, 0);
    run_case(1'b0, 0, 1, 400);
    run_case(1'b1, 0, 0, 0);
    run_case(1'b0, 255, 2, 180);
    run_case(1'b1, 255, 3, 100);
    run_case(1'b1, 40, 5, 300);
    late_vid();
    for (int i = 0; i < 10; i++)
      run_case(1'($urandom_range(0, 1)), int'($urandom_range(0, 255)),
               int'($urandom_range(0, 5)), int'($urandom_range(0, 300)));
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule